// File: doc/BRIEF.md
# GPIO Port Register Bank

This block holds the configuration and data registers for six 16-pin general-purpose I/O ports, which is 96 pads in all. Pad `n` is bit `n mod 16` of port `n / 16`. Software reaches the registers through a simple 32-bit read/write bus. The registers of port `p` start at byte address `p * 0x24`.

Each pad has a 4-bit mode code. The code selects one of the following:
- disabled;
- an input, with or without pull and filter;
- a push-pull output;
- an open-drain style output that drives only high (wired-OR);
- an open-drain style output that drives only low (wired-AND).

The block turns the mode code and the pad's output bit into a pad value and an output enable. It also produces decoded control levels for the analog pad cell: input buffer enable, pull enable, pull direction, glitch filter and high drive.

Output bits can be changed without a read-modify-write through two write-only aliases, one that sets bits and one that clears them. Pad levels pass through a two-flop synchronizer and can then be read back.

Top module: `gpio_bank`

## Requirements
- R1: After the asynchronous active-low reset, all mode codes and output bits are 0. Every `pad_oe_o`, `pad_out_o` and decoded control bit is 0, and reads of the mode and output registers return 0.
- R2: A read request (`req_i`=1, `we_i`=0) is answered one cycle later with `rvalid_o`=1 and the data on `rdata_o`. `rvalid_o` is 0 in every cycle that does not follow a read request. Within port `p` (base `p*0x24`), the offsets are: mode-low +0x04, mode-high +0x08, output data +0x0C, set alias +0x10, clear alias +0x14, input data +0x1C.
- R3: The mode code of pin `i` sits at bits `[4*(i mod 8)+3 : 4*(i mod 8)]`. Pins 0–7 are in mode-low and pins 8–15 in mode-high. Both registers read back what was written.
- R4: Output data (bits 15:0) is written and read directly. Writing 1s to the set alias sets those output bits, and writing 1s to the clear alias clears them. Zero bits leave their output bits unchanged. Both aliases read as 0.
- R5: Mode codes 4 and 5 (push-pull) drive the pad at all times: `pad_oe_o`=1 and `pad_out_o` = output bit.
- R6: Mode codes 6 and 7 (wired-OR) give `pad_out_o`=1, with `pad_oe_o` equal to the output bit.
- R7: Mode codes 8 to 12 (wired-AND) give `pad_out_o`=0, with `pad_oe_o` equal to the inverted output bit.
- R8: Mode codes 0 to 3 and 13 to 15 never drive the pad: `pad_oe_o`=0 and `pad_out_o`=0.
- R9: Pad levels pass through two flops. After a pad changes, reads sampled at the first two rising edges return the old level and a read at the third returns the new one. Input data reads 0 for any pin whose mode is disabled (0 or 13–15).
- R10: Decoded controls follow the mode code as listed below.
  - `in_en_o` is 1 for codes 1–12.
  - `pull_en_o` is 1 for codes 2, 3, 7, 10 and 11.
  - `pull_up_o` is 1 for codes 10 and 11, and equals the output bit for codes 2 and 3.
  - `filt_en_o` is 1 for codes 3, 9 and 11.
  - `drive_o` is 1 for codes 5 and 12.
- R11: Accesses to unmapped offsets behave as if nothing is there. This covers offsets +0x00, +0x18 and +0x20 of every port, and addresses at or above `6*0x24`. Reads return 0 and writes change no register or pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 9 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| pad_in_i | input | 96 | Asynchronous pad input levels |
| pad_out_o | output | 96 | Pad output value |
| pad_oe_o | output | 96 | Pad output enable |
| in_en_o | output | 96 | Input buffer enable |
| pull_en_o | output | 96 | Pull resistor enable |
| pull_up_o | output | 96 | Pull direction, 1 = up |
| filt_en_o | output | 96 | Input glitch filter enable |
| drive_o | output | 96 | High drive strength |

## Verification
A corrupted mode or output register shows up on the pad wires in the same cycle as the bad write, because the pad outputs and decoded controls are combinational from the registers. The bench compares all 96 pads against a model after every configuration step, so such an error is caught at that step. A wrong alias or unmapped-address write leaves a wrong output bit that is caught on the next readback, one cycle after the read request. A synchronizer with the wrong depth shifts the point at which a new pad level appears. Back-to-back reads at the first three edges after a change catch this: the third read is the first that may return the new level.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [3:0] {
    M_OFF         = 4'h0,
    M_IN          = 4'h1,
    M_IN_PULL     = 4'h2,
    M_IN_PULL_FLT = 4'h3,
    M_PP          = 4'h4,
    M_PP_DRV      = 4'h5,
    M_WOR         = 4'h6,
    M_WOR_PD      = 4'h7,
    M_WAND        = 4'h8,
    M_WAND_FLT    = 4'h9,
    M_WAND_PU     = 4'hA,
    M_WAND_PU_FLT = 4'hB,
    M_WAND_DRV    = 4'hC
  } pin_mode_e;

  typedef struct packed {
    logic out;
    logic oe;
    logic in_en;
    logic pull_en;
    logic pull_up;
    logic filt;
    logic drive;
  } pad_ctl_t;

  localparam int unsigned OFF_MODE_LO = 'h04;
  localparam int unsigned OFF_MODE_HI = 'h08;
  localparam int unsigned OFF_DOUT    = 'h0C;
  localparam int unsigned OFF_SET     = 'h10;
  localparam int unsigned OFF_CLR     = 'h14;
  localparam int unsigned OFF_DIN     = 'h1C;

endpackage

// File: rtl/gpio_pin_dec.sv
module gpio_pin_dec
  import gpio_bank_pkg::*;
(
  input  logic [3:0] mode_i,
  input  logic       dout_i,
  output pad_ctl_t   ctl_o
);

  always_comb begin
    ctl_o = '0;
    case (mode_i)
      M_IN:          ctl_o.in_en = 1'b1;
      M_IN_PULL:     begin ctl_o.in_en = 1'b1; ctl_o.pull_en = 1'b1; ctl_o.pull_up = dout_i; end
      M_IN_PULL_FLT: begin
        ctl_o.in_en = 1'b1; ctl_o.pull_en = 1'b1; ctl_o.pull_up = dout_i; ctl_o.filt = 1'b1;
      end
      M_PP:          begin ctl_o.in_en = 1'b1; ctl_o.oe = 1'b1; ctl_o.out = dout_i; end
      M_PP_DRV:      begin
        ctl_o.in_en = 1'b1; ctl_o.oe = 1'b1; ctl_o.out = dout_i; ctl_o.drive = 1'b1;
      end
      M_WOR:         begin ctl_o.in_en = 1'b1; ctl_o.oe = dout_i; ctl_o.out = 1'b1; end
      M_WOR_PD:      begin
        ctl_o.in_en = 1'b1; ctl_o.oe = dout_i; ctl_o.out = 1'b1; ctl_o.pull_en = 1'b1;
      end
      M_WAND:        begin ctl_o.in_en = 1'b1; ctl_o.oe = ~dout_i; end
      M_WAND_FLT:    begin ctl_o.in_en = 1'b1; ctl_o.oe = ~dout_i; ctl_o.filt = 1'b1; end
      M_WAND_PU:     begin
        ctl_o.in_en = 1'b1; ctl_o.oe = ~dout_i; ctl_o.pull_en = 1'b1; ctl_o.pull_up = 1'b1;
      end
      M_WAND_PU_FLT: begin
        ctl_o.in_en = 1'b1; ctl_o.oe = ~dout_i; ctl_o.pull_en = 1'b1; ctl_o.pull_up = 1'b1;
        ctl_o.filt = 1'b1;
      end
      M_WAND_DRV:    begin ctl_o.in_en = 1'b1; ctl_o.oe = ~dout_i; ctl_o.drive = 1'b1; end
      default:       ctl_o = '0; // off and reserved codes
    endcase
  end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS   = 16,
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned BASE   = 0,
  parameter int unsigned STRIDE = 36
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [PINS-1:0]       din_i,
  output logic [PINS*4-1:0]     mode_o,
  output logic [PINS-1:0]       dout_o
);

  localparam int unsigned HALF = PINS / 2;

  logic [PINS-1:0][3:0] mode_q;
  logic [PINS-1:0]      dout_q;
  logic [ADDR_W-1:0]    off;
  logic                 hit, wr;

  assign off = addr_i - ADDR_W'(BASE);
  assign hit = (addr_i >= ADDR_W'(BASE)) && (off < ADDR_W'(STRIDE));
  assign wr  = req_i && we_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      dout_q <= '0;
    end else if (wr) begin
      case (off)
        ADDR_W'(OFF_MODE_LO): for (int i = 0; i < HALF; i++) mode_q[i] <= wdata_i[4*i +: 4];
        ADDR_W'(OFF_MODE_HI): for (int i = 0; i < HALF; i++) mode_q[HALF+i] <= wdata_i[4*i +: 4];
        ADDR_W'(OFF_DOUT):    dout_q <= wdata_i[PINS-1:0];
        ADDR_W'(OFF_SET):     dout_q <= dout_q | wdata_i[PINS-1:0];
        ADDR_W'(OFF_CLR):     dout_q <= dout_q & ~wdata_i[PINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      case (off)
        ADDR_W'(OFF_MODE_LO): for (int i = 0; i < HALF; i++) rdata_o[4*i +: 4] = mode_q[i];
        ADDR_W'(OFF_MODE_HI): for (int i = 0; i < HALF; i++) rdata_o[4*i +: 4] = mode_q[HALF+i];
        ADDR_W'(OFF_DOUT):    rdata_o[PINS-1:0] = dout_q;
        ADDR_W'(OFF_DIN):     rdata_o[PINS-1:0] = din_i;
        default: ;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign dout_o = dout_q;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned PINS      = 16,
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned STRIDE    = 36
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [31:0]                   wdata_i,
  output logic [31:0]                   rdata_o,
  output logic                          rvalid_o,
  input  logic [NUM_PORTS*PINS-1:0]     pad_in_i,
  output logic [NUM_PORTS*PINS-1:0]     pad_out_o,
  output logic [NUM_PORTS*PINS-1:0]     pad_oe_o,
  output logic [NUM_PORTS*PINS-1:0]     in_en_o,
  output logic [NUM_PORTS*PINS-1:0]     pull_en_o,
  output logic [NUM_PORTS*PINS-1:0]     pull_up_o,
  output logic [NUM_PORTS*PINS-1:0]     filt_en_o,
  output logic [NUM_PORTS*PINS-1:0]     drive_o
);

  localparam int unsigned NPIN = NUM_PORTS * PINS;

  logic [NPIN-1:0]              sync_in, din_masked, dout_all;
  logic [NPIN*4-1:0]            mode_flat;
  logic [NUM_PORTS-1:0][31:0]   port_rd;
  logic [31:0]                  rd_mux, rdata_q;
  logic                         rvalid_q;

  gpio_sync #(.WIDTH(NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (sync_in)
  );

  assign din_masked = sync_in & in_en_o;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_port #(
      .PINS  (PINS),
      .ADDR_W(ADDR_W),
      .BASE  (p * STRIDE),
      .STRIDE(STRIDE)
    ) u_port (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req_i),
      .we_i   (we_i),
      .addr_i (addr_i),
      .wdata_i(wdata_i),
      .rdata_o(port_rd[p]),
      .din_i  (din_masked[p*PINS +: PINS]),
      .mode_o (mode_flat[p*PINS*4 +: PINS*4]),
      .dout_o (dout_all[p*PINS +: PINS])
    );
  end

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    pad_ctl_t ctl;
    gpio_pin_dec u_dec (
      .mode_i(mode_flat[4*n +: 4]),
      .dout_i(dout_all[n]),
      .ctl_o (ctl)
    );
    assign pad_out_o[n] = ctl.out;
    assign pad_oe_o[n]  = ctl.oe;
    assign in_en_o[n]   = ctl.in_en;
    assign pull_en_o[n] = ctl.pull_en;
    assign pull_up_o[n] = ctl.pull_up;
    assign filt_en_o[n] = ctl.filt;
    assign drive_o[n]   = ctl.drive;
  end

  // at most one port decodes a given address
  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++) rd_mux = rd_mux | port_rd[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPIN   = 96,
  parameter int unsigned ADDR_W = 9
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [15:0]         wdata_i,
  input logic                rvalid_o,
  input logic [NPIN-1:0]     pad_oe_o,
  input logic [NPIN-1:0]     dout_i,
  input logic [NPIN*4-1:0]   mode_i
);

  AST_READ_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o); // R2
  AST_SET_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFF_SET))
      |=> ((dout_i[15:0] & $past(wdata_i)) == $past(wdata_i))); // R4
  AST_CLR_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFF_CLR))
      |=> ((dout_i[15:0] & $past(wdata_i)) == 16'h0)); // R4
  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(dout_i)); // R4

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      for (int i = 0; i < NPIN; i++) begin
        AST_OE_NEEDS_OUT_MODE: assert (!pad_oe_o[i] ||
          (mode_i[4*i +: 4] >= 4'h4 && mode_i[4*i +: 4] <= 4'hC)); // R8
      end
    end
  end

endmodule

bind gpio_bank gpio_bank_chk #(
  .NPIN  (NUM_PORTS * PINS),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i[15:0]),
  .rvalid_o(rvalid_o),
  .pad_oe_o(pad_oe_o),
  .dout_i  (dout_all),
  .mode_i  (mode_flat)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;

  localparam int NP = 96;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, in_en, pull_en, pull_up, filt_en, drive;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [3:0]    bmode [NP];
  logic [NP-1:0] bdout = '0;

  always #5 clk = ~clk;

  gpio_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .in_en_o(in_en), .pull_en_o(pull_en),
    .pull_up_o(pull_up), .filt_en_o(filt_en), .drive_o(drive)
  );

  task automatic check(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // {out, oe, in_en, pull_en, pull_up, filt, drive}
  function automatic logic [6:0] model(input logic [3:0] m, input logic d);
    case (m)
      4'h1: return 7'b0010000;
      4'h2: return {4'b0011, d, 2'b00};
      4'h3: return {4'b0011, d, 2'b10};
      4'h4: return {d, 6'b110000};
      4'h5: return {d, 6'b110001};
      4'h6: return {1'b1, d, 5'b10000};
      4'h7: return {1'b1, d, 5'b11000};
      4'h8: return {1'b0, ~d, 5'b10000};
      4'h9: return {1'b0, ~d, 5'b10010};
      4'hA: return {1'b0, ~d, 5'b11100};
      4'hB: return {1'b0, ~d, 5'b11110};
      4'hC: return {1'b0, ~d, 5'b10001};
      default: return 7'b0;
    endcase
  endfunction

  task automatic chk_pads(string tag);
    logic [NP-1:0] e_out, e_oe, e_in, e_pe, e_pu, e_f, e_d;
    for (int n = 0; n < NP; n++)
      {e_out[n], e_oe[n], e_in[n], e_pe[n], e_pu[n], e_f[n], e_d[n]} = model(bmode[n], bdout[n]);
    check({tag, " R5 R6 R7 R8 pad_out"}, pad_out, e_out);
    check({tag, " R5 R6 R7 R8 pad_oe"}, pad_oe, e_oe);
    check({tag, " R10 in_en"}, in_en, e_in);
    check({tag, " R10 pull_en"}, pull_en, e_pe);
    check({tag, " R10 pull_up"}, pull_up, e_pu);
    check({tag, " R10 filt_en"}, filt_en, e_f);
    check({tag, " R10 drive"}, drive, e_d);
  endtask

  function automatic logic [15:0] din_mask(input int p);
    logic [15:0] m;
    for (int i = 0; i < 16; i++) m[i] = (bmode[p*16+i] >= 4'h1 && bmode[p*16+i] <= 4'hC);
    return m;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    int p, o;
    req = 1; we = 1; addr = 9'(a); wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    p = a / 36; o = a % 36;
    if (p < 6) begin
      case (o)
        4:  for (int i = 0; i < 8; i++) bmode[p*16+i]   = d[4*i +: 4];
        8:  for (int i = 0; i < 8; i++) bmode[p*16+8+i] = d[4*i +: 4];
        12: bdout[p*16 +: 16] = d[15:0];
        16: bdout[p*16 +: 16] = bdout[p*16 +: 16] | d[15:0];
        20: bdout[p*16 +: 16] = bdout[p*16 +: 16] & ~d[15:0];
        default: ;
      endcase
    end
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req = 1; we = 0; addr = 9'(a);
    @(negedge clk);
    req = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R2 unexpected rvalid: actual %h expected none", rdata);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (rdata !== e) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, rdata, e);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    for (int n = 0; n < NP; n++) bmode[n] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    chk_pads("R1 reset");
    rd('h04, 32'h0, "R1 mode-low after reset");
    rd('h0C, 32'h0, "R1 output data after reset");

    wr('h04, 32'hD1C87654);
    wr('h08, 32'h000BA932);
    rd('h04, 32'hD1C87654, "R3 mode-low readback");
    rd('h08, 32'h000BA932, "R3 mode-high readback");
    chk_pads("dout 0");

    wr('h10, 32'h0000003F);
    rd('h0C, 32'h0000003F, "R4 set alias");
    chk_pads("dout 3F");

    wr('h14, 32'h00000005);
    rd('h0C, 32'h0000003A, "R4 clear alias");
    rd('h10, 32'h0, "R4 set alias reads 0");
    rd('h14, 32'h0, "R4 clear alias reads 0");
    chk_pads("dout 3A");

    wr('h0C, 32'h0000FFFF);
    rd('h0C, 32'h0000FFFF, "R4 direct write");
    chk_pads("dout FFFF");

    wr('h28, 32'h00000004);
    wr('h34, 32'h00000001);
    rd('h28, 32'h00000004, "R2 port1 stride");
    rd('h30, 32'h00000001, "R2 port1 output data");
    chk_pads("port1");

    pad_in[15:0] = 16'hFFFF;
    rd('h1C, 32'h0, "R9 sync edge1 old");
    rd('h1C, 32'h0, "R9 sync edge2 old");
    rd('h1C, {16'h0, din_mask(0)}, "R9 sync edge3 new, disabled masked");

    wr('hB8, 32'h00000001);
    pad_in[81:80] = 2'b11;
    repeat (3) @(negedge clk);
    rd('hD0, 32'h00000001, "R9 port5 input, pin81 disabled");

    wr('h00, 32'hFFFFFFFF);
    wr('h18, 32'hFFFFFFFF);
    wr('h20, 32'hFFFFFFFF);
    wr('hD8, 32'hFFFFFFFF);
    wr('h1FF, 32'hFFFFFFFF);
    rd('h00, 32'h0, "R11 offset 00 reads 0");
    rd('h18, 32'h0, "R11 offset 18 reads 0");
    rd('h20, 32'h0, "R11 offset 20 reads 0");
    rd('hD8, 32'h0, "R11 beyond last port reads 0");
    rd('h0C, 32'h0000FFFF, "R11 output data intact");
    rd('h04, 32'hD1C87654, "R11 mode-low intact");
    rd('hBC, 32'h0, "R11 port5 mode-high intact");
    chk_pads("R11 after unmapped writes");

    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing responses: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule